// File: doc/BRIEF.md
# Windowed Watchdog Timer Controller

This block is a watchdog that counts strobes of a slow low-power tick of about 31 kHz. The tick passes through a prescaler, 32 or 128 ticks long, and then through a postscaler that multiplies that base period by a power of two picked by a 4-bit code. If the count runs out before software restarts it, the block raises a watchdog event. In run mode the event becomes a one-cycle reset request. In idle or sleep it becomes a one-cycle wake request instead. Either way it sets a sticky timeout flag that only software can clear.

A configuration field selects the enable policy: off, on only while awake, under software control, or always on. An optional fixed window turns a restart that comes too early into a fault. Outside that window the only accepted restart is one made in the last quarter of the programmed period. A clear strobe restarts both counters, and so do a power-save strobe, a clock-switch-completion strobe and an exit from sleep or idle. All inputs are sampled on the system clock. The slow tick arrives as a single-cycle enable pulse.

Top module: `wdt_window_ctrl`

## Requirements
- R1: While `rst_ni` is low, and on the first cycle after it is released, `rst_req_o`, `wake_o` and `tout_flag_o` are 0 and the software enable bit is 0.
- R2: `cfg_en_mode_i` decodes as follows: 2'b11 means always enabled, 2'b10 means enabled when the software enable bit is 1, 2'b01 means enabled when `pwr_mode_i` is 2'b00 (run) or 2'b01 (idle) with the software bit ignored, and 2'b00 means never enabled. A disabled watchdog holds its counters at zero and raises no event.
- R3: The base period is 32 ticks when `cfg_pre_long_i` is 0 and 128 ticks when it is 1.
- R4: The watchdog period is 2^`cfg_post_code_i` base periods. The event is raised on the tick that completes that period, counted from the last restart.
- R5: A timeout while `pwr_mode_i` is 2'b00 drives `rst_req_o` high for exactly the one cycle after the completing tick, and `wake_o` stays low.
- R6: With `cfg_win_off_i` = 0, a `clr_i` on an enabled watchdog whose elapsed tick count is below 3/4 of the period drives `rst_req_o` high on the next cycle, in any power mode. A clear at or after that point raises nothing. With `cfg_win_off_i` = 1, a clear never raises anything.
- R7: A timeout while `pwr_mode_i` is 2'b01 (idle) or 2'b10/2'b11 (sleep) drives `wake_o` high for one cycle, and `rst_req_o` stays low.
- R8: Every event sets `tout_flag_o` on the same edge that raises its request. The flag stays set until `flag_clr_i` is sampled high. If a clear and an event coincide, the flag ends up set.
- R9: `clr_i`, `psave_i`, `clksw_done_i` and `pwr_exit_i` each reset both counts to zero, so the next timeout comes a full period after the strobe.
- R10: A `clr_i` while the watchdog is disabled never causes a window fault.
- R11: A clear on the same cycle as the completing tick wins: there is no event, and counting restarts from zero.
- R12: The software enable bit takes `sw_en_d_i` on each cycle where `sw_en_we_i` is high, holds otherwise, and returns to 0 on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low device reset |
| tick_i | input | 1 | Single-cycle strobe of the slow tick |
| cfg_en_mode_i | input | 2 | Enable policy code |
| cfg_win_off_i | input | 1 | 1 disables the early-clear window check |
| cfg_pre_long_i | input | 1 | 1 selects the 128-tick base period |
| cfg_post_code_i | input | POST_CODE_W | Postscale exponent |
| sw_en_we_i | input | 1 | Write strobe for the software enable bit |
| sw_en_d_i | input | 1 | Value written to the software enable bit |
| clr_i | input | 1 | Watchdog clear strobe |
| psave_i | input | 1 | Power-save entry strobe |
| clksw_done_i | input | 1 | Clock switch completion strobe |
| pwr_exit_i | input | 1 | Exit from sleep or idle strobe |
| pwr_mode_i | input | 2 | 00 run, 01 idle, 10/11 sleep |
| flag_clr_i | input | 1 | Software clear of the timeout flag |
| rst_req_o | output | 1 | One-cycle reset request |
| wake_o | output | 1 | One-cycle wake request |
| tout_flag_o | output | 1 | Sticky watchdog event flag |

## Verification
Each input is sampled on one edge, and every request and the flag are due on the output one cycle later. The software enable bit changes at that edge too, but it only affects the enable decision from the cycle after. The bench changes its inputs on the falling edge and updates its own model on the rising edge from those same inputs. It compares all three outputs on the following falling edge, so the reset or wake pulse is expected exactly one cycle after the completing tick or the early clear. The directed cases count ticks from a restart to reach elapsed counts of 10, 24 and 31, and the full period, so the window edge and the clear-against-timeout collision land on known cycles.

// File: rtl/wdt_win_pkg.sv
`timescale 1ns/1ps
package wdt_win_pkg;

   typedef enum logic [1:0] {
      PWR_RUN   = 2'b00,
      PWR_IDLE  = 2'b01,
      PWR_SLEEP = 2'b10,
      PWR_RSVD  = 2'b11
   } pwr_e;

   typedef enum logic [1:0] {
      ENM_OFF   = 2'b00,
      ENM_AWAKE = 2'b01,
      ENM_SOFT  = 2'b10,
      ENM_ON    = 2'b11
   } enmode_e;

   typedef struct packed {
      logic clr;
      logic psave;
      logic clksw;
      logic pwr_exit;
   } restart_t;

endpackage

// File: rtl/wdt_en_dec.sv
`timescale 1ns/1ps
module wdt_en_dec
   import wdt_win_pkg::*;
(
   input  logic [1:0] mode_i,
   input  logic       sw_en_i,
   input  logic [1:0] pwr_i,
   output logic       en_o
);

   logic awake;
   assign awake = (pwr_i == PWR_RUN) || (pwr_i == PWR_IDLE);

   always_comb begin
      case (enmode_e'(mode_i))
         ENM_ON:    en_o = 1'b1;
         ENM_SOFT:  en_o = sw_en_i;
         ENM_AWAKE: en_o = awake;
         default:   en_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/wdt_prescale.sv
`timescale 1ns/1ps
module wdt_prescale #(
   parameter int SHORT_W = 5,
   parameter int LONG_W  = 7
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              en_i,
   input  logic              restart_i,
   input  logic              long_i,
   output logic [LONG_W-1:0] cnt_o,
   output logic              wrap_o
);

   localparam logic [LONG_W-1:0] TOP_LONG  = {LONG_W{1'b1}};
   localparam logic [LONG_W-1:0] TOP_SHORT = LONG_W'((64'd1 << SHORT_W) - 64'd1);

   generate
      if (SHORT_W < 2 || LONG_W < SHORT_W) begin : g_bad_width
         $error("wdt_prescale: need 2 <= SHORT_W <= LONG_W");
      end
   endgenerate

   logic [LONG_W-1:0] cnt_q;
   logic [LONG_W-1:0] top_val;

   assign top_val = long_i ? TOP_LONG : TOP_SHORT;
   assign wrap_o  = tick_i & en_i & ~restart_i & (cnt_q == top_val);
   assign cnt_o   = cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 cnt_q <= '0;
      else if (restart_i || !en_i) cnt_q <= '0;
      else if (tick_i)             cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
   end

   // R9: any restart strobe empties the prescaler
   a_r9_pre_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
      restart_i |=> (cnt_q == '0));

   // R3: after the base period completes the count starts over
   a_r3_pre_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wrap_o |=> (cnt_q == '0));

endmodule

// File: rtl/wdt_postscale.sv
`timescale 1ns/1ps
module wdt_postscale #(
   parameter int CODE_W = 4,
   parameter int POST_W = 15
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              en_i,
   input  logic              restart_i,
   input  logic              base_i,
   input  logic [CODE_W-1:0] code_i,
   output logic [POST_W-1:0] cnt_o,
   output logic              last_o
);

   localparam int MAX_EXP = (1 << CODE_W) - 1;

   generate
      if (POST_W < MAX_EXP || POST_W < 1) begin : g_bad_width
         $error("wdt_postscale: POST_W must cover the largest exponent");
      end
   endgenerate

   logic [POST_W-1:0] cnt_q;
   logic [POST_W-1:0] lim;

   // limit = 2^code - 1, built one bit at a time
   generate
      for (genvar i = 0; i < POST_W; i++) begin : g_lim
         assign lim[i] = (32'(code_i) > i);
      end
   endgenerate

   assign last_o = (cnt_q == lim);
   assign cnt_o  = cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 cnt_q <= '0;
      else if (restart_i || !en_i) cnt_q <= '0;
      else if (base_i)             cnt_q <= last_o ? '0 : cnt_q + 1'b1;
   end

   // R9: any restart strobe empties the postscaler
   a_r9_post_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
      restart_i |=> (cnt_q == '0));

   // R2: a disabled watchdog keeps its postscaler empty
   a_r2_post_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> (cnt_q == '0));

endmodule

// File: rtl/wdt_window.sv
`timescale 1ns/1ps
module wdt_window #(
   parameter int SHORT_W = 5,
   parameter int LONG_W  = 7,
   parameter int CODE_W  = 4,
   parameter int POST_W  = 15
) (
   input  logic              long_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic [LONG_W-1:0] pre_i,
   input  logic [POST_W-1:0] post_i,
   output logic              open_o
);

   localparam int EL_W = POST_W + LONG_W;

   logic [EL_W-1:0] elapsed;
   logic [EL_W-1:0] thresh;
   logic [7:0]      shift;

   always_comb begin
      if (long_i) begin
         elapsed = {post_i, pre_i};
         shift   = 8'(code_i) + 8'(LONG_W - 2);
      end else begin
         elapsed = (EL_W'(post_i) << SHORT_W) | EL_W'(pre_i);
         shift   = 8'(code_i) + 8'(SHORT_W - 2);
      end
      // three quarters of 2^(code + prescale width)
      thresh = EL_W'(3) << shift;
      open_o = (elapsed >= thresh);
   end

endmodule

// File: rtl/wdt_window_ctrl.sv
`timescale 1ns/1ps
module wdt_window_ctrl
   import wdt_win_pkg::*;
#(
   parameter int PRE_SHORT_W = 5,
   parameter int PRE_LONG_W  = 7,
   parameter int POST_CODE_W = 4
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   tick_i,
   input  logic [1:0]             cfg_en_mode_i,
   input  logic                   cfg_win_off_i,
   input  logic                   cfg_pre_long_i,
   input  logic [POST_CODE_W-1:0] cfg_post_code_i,
   input  logic                   sw_en_we_i,
   input  logic                   sw_en_d_i,
   input  logic                   clr_i,
   input  logic                   psave_i,
   input  logic                   clksw_done_i,
   input  logic                   pwr_exit_i,
   input  logic [1:0]             pwr_mode_i,
   input  logic                   flag_clr_i,
   output logic                   rst_req_o,
   output logic                   wake_o,
   output logic                   tout_flag_o
);

   localparam int POST_W = (1 << POST_CODE_W) - 1;

   restart_t             rs;
   logic                 restart;
   logic                 wdt_en;
   logic                 sw_en_q;
   logic [PRE_LONG_W-1:0] pre_cnt;
   logic [POST_W-1:0]    post_cnt;
   logic                 base_tick;
   logic                 post_last;
   logic                 win_open;
   logic                 timeout;
   logic                 fault;
   logic                 asleep;
   logic                 rst_q, wake_q, flag_q;

   assign rs      = '{clr: clr_i, psave: psave_i, clksw: clksw_done_i, pwr_exit: pwr_exit_i};
   assign restart = |rs;

   wdt_en_dec u_en (
      .mode_i  (cfg_en_mode_i),
      .sw_en_i (sw_en_q),
      .pwr_i   (pwr_mode_i),
      .en_o    (wdt_en)
   );

   wdt_prescale #(.SHORT_W(PRE_SHORT_W), .LONG_W(PRE_LONG_W)) u_pre (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick_i),
      .en_i      (wdt_en),
      .restart_i (restart),
      .long_i    (cfg_pre_long_i),
      .cnt_o     (pre_cnt),
      .wrap_o    (base_tick)
   );

   wdt_postscale #(.CODE_W(POST_CODE_W), .POST_W(POST_W)) u_post (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (wdt_en),
      .restart_i (restart),
      .base_i    (base_tick),
      .code_i    (cfg_post_code_i),
      .cnt_o     (post_cnt),
      .last_o    (post_last)
   );

   wdt_window #(
      .SHORT_W (PRE_SHORT_W),
      .LONG_W  (PRE_LONG_W),
      .CODE_W  (POST_CODE_W),
      .POST_W  (POST_W)
   ) u_win (
      .long_i (cfg_pre_long_i),
      .code_i (cfg_post_code_i),
      .pre_i  (pre_cnt),
      .post_i (post_cnt),
      .open_o (win_open)
   );

   // base_tick already excludes restart cycles, so a clear beats a timeout
   assign timeout = base_tick & post_last;
   assign fault   = clr_i & wdt_en & ~cfg_win_off_i & ~win_open;
   assign asleep  = (pwr_mode_i != PWR_RUN);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rst_q   <= 1'b0;
         wake_q  <= 1'b0;
         flag_q  <= 1'b0;
         sw_en_q <= 1'b0;
      end else begin
         rst_q  <= fault | (timeout & ~asleep);
         wake_q <= timeout & asleep;
         if (fault || timeout) flag_q <= 1'b1;
         else if (flag_clr_i)  flag_q <= 1'b0;
         if (sw_en_we_i)       sw_en_q <= sw_en_d_i;
      end
   end

   assign rst_req_o   = rst_q;
   assign wake_o      = wake_q;
   assign tout_flag_o = flag_q;

   // R7: a single event never asks for both reset and wake
   a_r7_req_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(rst_req_o && wake_o));

   // R8: the flag accompanies every request
   a_r8_flag_with_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rst_req_o || wake_o) |-> tout_flag_o);

   // R8: only a software clear drops the flag
   a_r8_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tout_flag_o && !flag_clr_i) |=> tout_flag_o);

   // R2: mode 00 produces no request
   a_r2_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_en_mode_i == ENM_OFF) |=> (!rst_req_o && !wake_o));

   // R10: a clear on a disabled watchdog is never a fault
   a_r10_idle_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !wdt_en) |=> !rst_req_o);

   // R12: the software bit changes only through its write strobe
   a_r12_sw_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sw_en_we_i |=> $stable(sw_en_q));

endmodule

// File: tb/wdt_window_ctrl_bench.sv
`timescale 1ns/1ps
module wdt_window_ctrl_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 0, win_off = 1, pre_long = 0;
   logic [1:0] en_mode = 2'b00, pwr = 2'b00;
   logic [3:0] code = 4'd0;
   logic       sw_we = 0, sw_d = 0, clr = 0, psave = 0, clksw = 0, pexit = 0, fclr = 0;
   logic       rst_req, wake, flag;

   int total = 0;
   int bad   = 0;

   int  m_pre = 0, m_post = 0;
   bit  m_sw = 0, m_flag = 0, m_rst = 0, m_wake = 0, m_fault = 0;

   always #10 clk = ~clk;

   wdt_window_ctrl u_wdt_window_ctrl (
      .clk_i           (clk),
      .rst_ni          (rst_n),
      .tick_i          (tick),
      .cfg_en_mode_i   (en_mode),
      .cfg_win_off_i   (win_off),
      .cfg_pre_long_i  (pre_long),
      .cfg_post_code_i (code),
      .sw_en_we_i      (sw_we),
      .sw_en_d_i       (sw_d),
      .clr_i           (clr),
      .psave_i         (psave),
      .clksw_done_i    (clksw),
      .pwr_exit_i      (pexit),
      .pwr_mode_i      (pwr),
      .flag_clr_i      (fclr),
      .rst_req_o       (rst_req),
      .wake_o          (wake),
      .tout_flag_o     (flag)
   );

   function automatic bit exp_en(input logic [1:0] m, input bit s, input logic [1:0] p);
      case (m)
         2'b11:   return 1'b1;
         2'b10:   return s;
         2'b01:   return (p < 2);
         default: return 1'b0;
      endcase
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // reference model: one rising edge of the requirements
   task automatic model();
      int  p, n, el;
      bit  en, rs, to;
      if (!rst_n) begin
         m_pre = 0; m_post = 0; m_sw = 0; m_flag = 0;
         m_rst = 0; m_wake = 0; m_fault = 0;
         return;
      end
      p  = pre_long ? 128 : 32;
      n  = 1 << code;
      en = exp_en(en_mode, m_sw, pwr);
      rs = clr | psave | clksw | pexit;
      el = m_post * p + m_pre;
      m_fault = clr && en && !win_off && (el * 4 < 3 * n * p);
      to = tick && en && !rs && (m_pre == p - 1) && (m_post == n - 1);
      if (rs || !en) begin
         m_pre = 0; m_post = 0;
      end else if (tick) begin
         if (m_pre == p - 1) begin
            m_pre = 0;
            m_post = (m_post == n - 1) ? 0 : m_post + 1;
         end else m_pre++;
      end
      m_rst  = m_fault || (to && pwr == 2'b00);
      m_wake = to && pwr != 2'b00;
      if (m_fault || to) m_flag = 1;
      else if (fclr)     m_flag = 0;
      if (sw_we) m_sw = sw_d;
   endtask

   task automatic step();
      @(posedge clk);
      model();
      @(negedge clk);
      chk(m_fault ? "R6 reset" : "R5 reset", rst_req, m_rst);
      chk("R7 wake", wake, m_wake);
      chk("R8 flag", flag, m_flag);
   endtask

   task automatic run_ticks(input int k);
      tick = 1;
      repeat (k) step();
      tick = 0;
   endtask

   task automatic restart_clksw();
      clksw = 1; step(); clksw = 0;
   endtask

   initial begin
      #(20 * 190000);
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      @(negedge clk);
      step();
      // R1: reset state
      chk("R1 rst_req", rst_req, 0);
      chk("R1 wake", wake, 0);
      chk("R1 flag", flag, 0);
      rst_n = 1;
      step();
      chk("R1 flag after release", flag, 0);

      // R4/R5: code 1, short prescale -> 64 ticks in run mode
      en_mode = 2'b11; code = 4'd1; restart_clksw();
      run_ticks(63);
      chk("R4 no early timeout", rst_req, 0);
      run_ticks(1);
      chk("R5 reset on 64th tick", rst_req, 1);
      chk("R8 flag set", flag, 1);
      step();
      chk("R5 one cycle only", rst_req, 0);

      // R8: flag holds while disabled, then software clears it
      en_mode = 2'b00;
      repeat (40) step();
      chk("R8 flag sticky", flag, 1);
      fclr = 1; step(); fclr = 0;
      chk("R8 flag cleared", flag, 0);

      // R3: long prescale, code 0 -> 128 ticks
      en_mode = 2'b11; code = 4'd0; pre_long = 1; restart_clksw();
      run_ticks(127);
      chk("R3 long not yet", rst_req, 0);
      run_ticks(1);
      chk("R3 long period", rst_req, 1);
      pre_long = 0;

      // R6: window on, code 0, short: threshold 24
      win_off = 0; restart_clksw();
      run_ticks(10);
      clr = 1; step(); clr = 0;
      chk("R6 early clear faults", rst_req, 1);
      run_ticks(24);
      clr = 1; step(); clr = 0;
      chk("R6 clear in window", rst_req, 0);
      run_ticks(31);
      chk("R6 restarted count", rst_req, 0);
      run_ticks(1);
      chk("R6 full period after clear", rst_req, 1);

      // R11: clear on the completing tick wins
      fclr = 1; step(); fclr = 0;
      run_ticks(31);
      tick = 1; clr = 1; step(); tick = 0; clr = 0;
      chk("R11 no reset on collision", rst_req, 0);
      chk("R11 flag untouched", flag, 0);
      run_ticks(31);
      chk("R11 count restarted", rst_req, 0);

      // R10: disabled clear never faults
      en_mode = 2'b00; clr = 1; step(); clr = 0;
      chk("R10 disabled clear", rst_req, 0);

      // R9: power-save restart postpones timeout
      en_mode = 2'b11; win_off = 1; restart_clksw();
      run_ticks(20);
      psave = 1; step(); psave = 0;
      run_ticks(31);
      chk("R9 restart by power-save", rst_req, 0);
      run_ticks(1);
      chk("R9 full period after restart", rst_req, 1);

      // R7: idle timeout wakes
      pwr = 2'b01; pexit = 1; step(); pexit = 0;
      run_ticks(32);
      chk("R7 wake in idle", wake, 1);
      chk("R7 no reset in idle", rst_req, 0);

      // R2: mode 01 in sleep counts nothing
      pwr = 2'b10; en_mode = 2'b01; fclr = 1; step(); fclr = 0;
      run_ticks(100);
      chk("R2 awake-only mode asleep", flag, 0);

      // R12: software enable, then reset clears it
      pwr = 2'b00; en_mode = 2'b10; sw_we = 1; sw_d = 1; step(); sw_we = 0;
      run_ticks(32);
      chk("R12 soft enable active", rst_req, 1);
      rst_n = 0; step(); rst_n = 1;
      run_ticks(100);
      chk("R12 soft bit cleared by reset", flag, 0);

      // constrained random phase
      for (int i = 0; i < 30000; i++) begin
         tick  = ($urandom % 2) == 0;
         clr   = ($urandom % 90) == 0;
         psave = ($urandom % 400) == 0;
         pexit = ($urandom % 400) == 0;
         fclr  = ($urandom % 60) == 0;
         sw_we = ($urandom % 150) == 0;
         sw_d  = $urandom % 2;
         clksw = 0;
         if (($urandom % 300) == 0) pwr = 2'($urandom % 4);
         if (($urandom % 400) == 0) en_mode = 2'($urandom % 4);
         if (($urandom % 250) == 0) begin
            clksw    = 1;
            code     = 4'($urandom % 3);
            pre_long = ($urandom % 4) == 0;
            win_off  = $urandom % 2;
         end
         if (($urandom % 6000) == 0) rst_n = 0;
         step();
         rst_n = 1;
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule